// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven management-bus master that reads and writes the internal registers of an attached Ethernet PHY over a two-wire clock/data link. Software writes a single 32-bit command word holding the target PHY address, the PHY register number, a read/write opcode and, for writes, sixteen data bits. The controller then builds the complete serial frame and shifts it out on the management clock and data pins.

While a frame is on the wire, a busy bit in the same word reads as one. When a read frame ends, the sixteen bits returned by the PHY replace the data field and a read-valid bit is set. Software polls these two bits. The management clock is divided down from the system clock. The divider takes a run-time half-period setting, and a setting of zero selects a built-in default that keeps the clock at or below 2.5 MHz with a 50 MHz system clock. A separate five-bit register holds the port's own PHY address.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: A command word written while idle is accepted. Its fields are read back from `cmd_rdata`: data in bits 15:0, PHY address in 20:16, register number in 25:21, and the opcode in bit 26 (1 = read, 0 = write). Bits 31:29 read as zero.
- R2: The busy bit (bit 28 of `cmd_rdata`) is 0 after reset. It becomes 1 in the cycle after a command is accepted, stays 1 through the last bit of the frame, and then returns to 0.
- R3: A write frame is exactly 64 MDC cycles long, with every bit driven by the master and launched MSB first. The bits are 32 ones, then 01, then opcode 01, then the PHY address, then the register number, then turnaround 10, then the 16 data bits.
- R4: A read frame drives 32 ones, then 01, then opcode 10, then the PHY address and the register number. The master then releases MDIO (`mdio_oe` = 0) for the remaining 18 bit times: two turnaround bits and sixteen data bits.
- R5: On a read, the master samples 16 data bits MSB first on rising MDC edges. When busy clears, these bits appear in `cmd_rdata[15:0]` and the read-valid bit (bit 27) is 1. Read-valid is never 1 while busy is 1.
- R6: Accepting any new command clears read-valid in the following cycle.
- R7: A command word written while busy has no effect. The fields of the frame in progress, the frame on the wire and the frame count are all unchanged.
- R8: The MDC half-period equals `mdc_half` system clocks. When `mdc_half` is 0, the half-period is 10 system clocks, which gives 2.5 MHz at 50 MHz.
- R9: A write to the port PHY-address register loads bits 4:0 of `paddr_wdata` into `paddr_q` and ignores the upper bits. The register resets to 0 and does not affect the command word.
- R10: While idle, MDC is held low and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command/status word read back |
| paddr_wr | input | 1 | Write strobe for the port PHY-address register |
| paddr_wdata | input | 32 | Write data for the PHY-address register (low 5 bits used) |
| paddr_q | output | 5 | Current port PHY address |
| mdc_half | input | 8 | MDC half-period in system clocks (0 selects the default) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data as seen on the pin |

## Verification
The bench covers several boundary frames: all-zero and all-one address fields, all-zero and all-one write data, and reads at the extreme addresses. For each, it compares every captured wire bit and every output-enable value against a frame computed independently. A design with a misplaced field, a wrong opcode or a missing turnaround would corrupt a captured bit. A design that releases the line one bit late would fight the PHY, and the output-enable comparison would show it. A PHY model returns address-dependent data, so an off-by-one sampling edge or a reversed bit order shows up as wrong read data. The bench also writes a second command in the middle of a frame and checks for two faults: a design that accepts it would rewrite the readback fields or start an extra frame. Finally, it measures the MDC period with a programmed divider and with the default divider, and it checks that read-valid drops one cycle after the next command is accepted.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W       = 32;
  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 5;
  localparam int PRE_W       = 32;
  localparam int FRAME_W     = PRE_W + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W       = $clog2(FRAME_W);
  localparam int REL_IDX     = PRE_W + 2 + 2 + 2 * ADDR_W;   // first bit the master releases on a read
  localparam int CAP_IDX     = FRAME_W - DATA_W;             // first sampled data bit
  localparam int PHY_LSB     = 16;
  localparam int REG_LSB     = 21;
  localparam int OP_BIT      = 26;
  localparam int RVALID_BIT  = 27;
  localparam int BUSY_BIT    = 28;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] regad;
    logic [ADDR_W-1:0] phyad;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_cmd(logic [CMD_W-1:0] w);
    mdio_cmd_t c;
    c.rd    = w[OP_BIT];
    c.regad = w[REG_LSB +: ADDR_W];
    c.phyad = w[PHY_LSB +: ADDR_W];
    c.data  = w[DATA_W-1:0];
    return c;
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(mdio_cmd_t c);
    logic [1:0]        opc;
    logic [DATA_W+1:0] tail;
    opc  = c.rd ? 2'b10 : 2'b01;
    tail = c.rd ? '0 : {2'b10, c.data};
    return {{PRE_W{1'b1}}, 2'b01, opc, c.phyad, c.regad, tail};
  endfunction
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int HALF_W       = 8,
  parameter int DEFAULT_HALF = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half_sel,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d, half_eff;
  logic              wrap;

  assign half_eff = (half_sel == '0) ? HALF_W'(DEFAULT_HALF) : half_sel;
  assign wrap     = (cnt_q == half_eff - HALF_W'(1));
  assign tick     = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + HALF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_rd,
  input  logic [FRAME_W-1:0] frame,
  input  logic               tick,
  input  logic               mdio_i,
  output logic               busy,
  output logic               done,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rd_data
);
  logic               busy_q, busy_d;
  logic               rd_q, rd_d;
  logic               mdc_q, mdc_d;
  logic               oe_q, oe_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  cap_q, cap_d;
  logic               last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_W - 1));
  assign done     = busy_q && tick && mdc_q && last_bit;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    mdc_d  = mdc_q;
    oe_d   = oe_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    cap_d  = cap_q;
    if (start) begin
      busy_d = 1'b1;
      rd_d   = start_rd;
      mdc_d  = 1'b0;
      oe_d   = 1'b1;
      sh_d   = frame;
      idx_d  = '0;
      cap_d  = '0;
    end else if (busy_q && tick) begin
      if (!mdc_q) begin
        // rising MDC: sample returned data on a read
        mdc_d = 1'b1;
        if (rd_q && (idx_q >= IDX_W'(CAP_IDX)))
          cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end else begin
        // falling MDC: launch next bit or finish
        mdc_d = 1'b0;
        if (last_bit) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
          sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
          oe_d  = !(rd_q && (idx_q >= IDX_W'(REL_IDX - 1)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      mdc_q  <= 1'b0;
      oe_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      mdc_q  <= mdc_d;
      oe_q   <= oe_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign mdc     = mdc_q;
  assign mdio_oe = oe_q;
  assign mdio_o  = sh_q[FRAME_W-1] & oe_q;
  assign rd_data = cap_q;
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              accept,
  output mdio_cmd_t         new_cmd,
  output mdio_cmd_t         cmd,
  output logic              rvalid
);
  mdio_cmd_t cmd_q, cmd_d;
  logic      rv_q, rv_d;

  assign accept  = wr_en && !eng_busy;
  assign new_cmd = decode_cmd(wr_data);

  always_comb begin
    cmd_d = cmd_q;
    rv_d  = rv_q;
    if (accept) begin
      cmd_d = new_cmd;
      rv_d  = 1'b0;
    end else if (eng_done && cmd_q.rd) begin
      cmd_d.data = eng_rdata;
      rv_d       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      rv_q  <= rv_d;
    end
  end

  assign cmd    = cmd_q;
  assign rvalid = rv_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_W       = 8,
  parameter int DEFAULT_HALF = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_rdata,
  input  logic              paddr_wr,
  input  logic [CMD_W-1:0]  paddr_wdata,
  output logic [ADDR_W-1:0] paddr_q,
  input  logic [HALF_W-1:0] mdc_half,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              busy, done, tick, accept, rvalid;
  logic [DATA_W-1:0] rd_data;
  mdio_cmd_t         new_cmd, cmd;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic              unused_bits;

  assign unused_bits = ^{cmd_wdata[CMD_W-1:OP_BIT+1], paddr_wdata[CMD_W-1:ADDR_W]};

  mdio_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr), .wr_data(cmd_wdata),
    .eng_busy(busy), .eng_done(done), .eng_rdata(rd_data),
    .accept(accept), .new_cmd(new_cmd), .cmd(cmd), .rvalid(rvalid)
  );

  mdio_tick_gen #(.HALF_W(HALF_W), .DEFAULT_HALF(DEFAULT_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_sel(mdc_half), .tick(tick)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_rd(new_cmd.rd),
    .frame(build_frame(new_cmd)), .tick(tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  always_comb begin
    pa_d = pa_q;
    if (paddr_wr) pa_d = paddr_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pa_q <= '0;
    else        pa_q <= pa_d;
  end

  assign paddr_q   = pa_q;
  assign cmd_rdata = {3'b000, busy, rvalid, cmd.rd, cmd.regad, cmd.phyad, cmd.data};
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_oe
);
  logic busy, rvalid;
  assign busy   = cmd_rdata[28];
  assign rvalid = cmd_rdata[27];

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> busy);

  p_rvalid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !busy);

  p_rvalid_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy) |=> !rvalid);

  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> $stable(cmd_rdata[26:16]));

  p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rdata(cmd_rdata),
  .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_cmd_ctrl_tb_top.sv
module mdio_cmd_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_wr;
  logic [31:0] cmd_wdata;
  logic [31:0] cmd_rdata;
  logic        paddr_wr;
  logic [31:0] paddr_wdata;
  logic [4:0]  paddr_q;
  logic [7:0]  mdc_half;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #10 clk = ~clk;

  mdio_cmd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .paddr_wr(paddr_wr), .paddr_wdata(paddr_wdata),
    .paddr_q(paddr_q), .mdc_half(mdc_half), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] resp(logic [4:0] p, logic [4:0] r);
    return {p, r, 6'h15} ^ 16'h3C5A;
  endfunction

  // PHY model: captures master bits on rising MDC, answers reads on falling MDC
  int          idx = 0;
  logic [63:0] capw, capoe;
  logic        phy_en = 1'b0, phy_bit = 1'b0;
  assign mdio_i = phy_en ? phy_bit : 1'b1;

  always @(posedge mdc) begin
    if (idx < 64) begin
      capw[63-idx]  = mdio_o;
      capoe[63-idx] = mdio_oe;
    end
    idx = idx + 1;
  end

  always @(negedge mdc) begin
    if (idx >= 47 && idx <= 63 && capw[29:28] == 2'b10 && capoe[29]) begin
      phy_en  = 1'b1;
      phy_bit = (idx == 47) ? 1'b0 : resp(capw[27:23], capw[22:18])[63-idx];
    end else begin
      phy_en = 1'b0;
    end
  end

  // scoreboard
  typedef struct {
    logic [63:0] ef;
    logic [63:0] eoe;
    logic [31:0] erd;
    bit          rd;
  } exp_t;
  exp_t exp_q[$];

  task automatic issue(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    exp_t e;
    logic [15:0] dv;
    e.rd  = rd;
    e.ef  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, (rd ? 18'h0 : {2'b10, d})};
    e.eoe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    dv    = rd ? resp(p, r) : d;
    e.erd = {3'b000, 1'b0, rd, rd, r, p, dv};
    exp_q.push_back(e);
    @(negedge clk);
    chk(cmd_rdata[28] == 1'b0, "R2", "busy before accept", 64'(cmd_rdata[28]), 64'd0);
    idx       = 0;
    cmd_wr    = 1'b1;
    cmd_wdata = {5'b0, rd, r, p, d};
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_rdata[28] == 1'b1, "R2", "busy after accept", 64'(cmd_rdata[28]), 64'd1);
    chk(cmd_rdata[27] == 1'b0, "R6", "read-valid after accept", 64'(cmd_rdata[27]), 64'd0);
    chk(cmd_rdata[26:16] == {rd, r, p}, "R1", "fields after accept",
        64'(cmd_rdata[26:16]), 64'({rd, r, p}));
  endtask

  task automatic wait_idle();
    wait (cmd_rdata[28] == 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    wait (rst_n === 1'b1);
    forever begin
      exp_t e;
      @(negedge cmd_rdata[28]);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected frame", 64'd1, 64'd0);
      end else begin
        e = exp_q.pop_front();
        chk((capw & e.eoe) == (e.ef & e.eoe), e.rd ? "R4" : "R3", "frame bits",
            capw & e.eoe, e.ef & e.eoe);
        chk(capoe == e.eoe, e.rd ? "R4" : "R3", "output enable", capoe, e.eoe);
        chk(idx == 64, "R3", "MDC cycle count", 64'(idx), 64'd64);
        chk(cmd_rdata == e.erd, e.rd ? "R5" : "R1", "readback word",
            64'(cmd_rdata), 64'(e.erd));
        chk(!mdc && !mdio_oe, "R10", "idle pins", 64'({mdc, mdio_oe}), 64'd0);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic measure(int exp_cycles);
    longint t0;
    @(posedge mdc);
    t0 = cyc;
    @(posedge mdc);
    chk((cyc - t0) == exp_cycles, "R8", "MDC period", 64'(cyc - t0), 64'(exp_cycles));
  endtask

  initial begin
    rst_n       = 1'b0;
    cmd_wr      = 1'b0;
    cmd_wdata   = '0;
    paddr_wr    = 1'b0;
    paddr_wdata = '0;
    mdc_half    = 8'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_rdata == 32'h0, "R2", "reset word", 64'(cmd_rdata), 64'd0);
    chk(!mdc && !mdio_oe, "R10", "reset pins", 64'({mdc, mdio_oe}), 64'd0);
    chk(paddr_q == 5'd0, "R9", "reset port address", 64'(paddr_q), 64'd0);

    // write frames, including boundary fields
    issue(1'b0, 5'd1, 5'd2, 16'hBEEF);   wait_idle();
    issue(1'b0, 5'd31, 5'd0, 16'h0000);  wait_idle();
    issue(1'b0, 5'd0, 5'd31, 16'hFFFF);  wait_idle();

    // reads
    issue(1'b1, 5'd5, 5'd1, 16'h0);      wait_idle();
    chk(cmd_rdata[27] == 1'b1, "R5", "read-valid after read", 64'(cmd_rdata[27]), 64'd1);
    issue(1'b0, 5'd9, 5'd3, 16'h1234);   wait_idle();
    issue(1'b1, 5'd31, 5'd31, 16'h0);    wait_idle();
    issue(1'b1, 5'd0, 5'd0, 16'h0);      wait_idle();

    // command during busy is ignored
    issue(1'b1, 5'd3, 5'd4, 16'h0);
    repeat (5) @(negedge clk);
    cmd_wr    = 1'b1;
    cmd_wdata = {5'b0, 1'b0, 5'd8, 5'd7, 16'hAAAA};
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_rdata[26:16] == {1'b1, 5'd4, 5'd3}, "R7", "fields during busy",
        64'(cmd_rdata[26:16]), 64'({1'b1, 5'd4, 5'd3}));
    wait_idle();
    repeat (50) @(negedge clk);
    chk(cmd_rdata[28] == 1'b0 && exp_q.size() == 0, "R7", "no extra frame",
        64'(exp_q.size()), 64'd0);

    // MDC divider: programmed and default
    mdc_half = 8'd5;
    issue(1'b0, 5'd2, 5'd6, 16'h5A5A);
    measure(10);
    wait_idle();
    mdc_half = 8'd0;
    issue(1'b1, 5'd17, 5'd9, 16'h0);
    measure(20);
    wait_idle();

    // port PHY-address register
    @(negedge clk);
    paddr_wr    = 1'b1;
    paddr_wdata = 32'hFFFF_FFE9;
    @(negedge clk);
    paddr_wr = 1'b0;
    chk(paddr_q == 5'd9, "R9", "port address upper bits ignored", 64'(paddr_q), 64'd9);
    paddr_wr    = 1'b1;
    paddr_wdata = 32'h0000_0016;
    @(negedge clk);
    paddr_wr = 1'b0;
    chk(paddr_q == 5'h16, "R9", "port address reload", 64'(paddr_q), 64'h16);
    chk(cmd_rdata == {3'b000, 1'b0, 1'b1, 1'b1, 5'd9, 5'd17, resp(5'd17, 5'd9)}, "R9",
        "command word untouched", 64'(cmd_rdata),
        64'({3'b000, 1'b0, 1'b1, 1'b1, 5'd9, 5'd17, resp(5'd17, 5'd9)}));

    chk(exp_q.size() == 0, "R3", "scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule